// File: doc/BRIEF.md
# Low-Power State and Wake Controller

This block sequences a chip through five power states: Off, Active, Shallow Sleep, Deep Sleep and Dormant. Software asks for a sleep depth with a request strobe. The controller accepts the request only from Active, and only when no enabled wake source is already firing. While the chip sleeps, the block watches the external wake inputs. These are a power-button pin, a charger-attach pin, a bus of general I/O lines, activity flags from the digital interfaces, the LED inputs and the debug port, a USB resume flag, and a wake timer counted on a 1 MHz tick. When a wake source is allowed, the block returns the chip to Active.

Each sleep depth has its own set of wake sources. Shallow and Deep sleep wake on any source that its mask bit enables. Dormant listens only to the button, the charger, I/O lines 1 to 8 and the timer. Leaving Off is different: it needs the button or the charger to stay high for a qualified hold time. A single edge does not leave Off. An external active-low reset pin that stays low long enough forces Off. Power rails and clocks are not driven here. The block only reports what they should do, through two status outputs.

All asynchronous pins pass through two-flop synchronizers. Every edge is detected on the synchronized copies.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After the synchronous reset `rst_n` is released, `pwr_state` is 0 (Off), `clk_reduce` is 1, `mem_pdown` is 1 and `wake` is 0.
- R2: From Off, the block moves to Active (`pwr_state` 1) only after `btn_pin` or `chg_pin` stays high for HOLD_TICKS consecutive ticks. The count is cleared whenever the pin is low, so shorter pulses leave the block in Off, even when several of them add up to more than HOLD_TICKS.
- R3: A `sleep_req` is acted on only in Active. The `sleep_mode` code selects the target: 1 gives Shallow (`pwr_state` 2), 2 gives Deep (3) and 3 gives Dormant (4). Code 0 is ignored.
- R4: If an enabled wake event is present in the cycle where `sleep_req` is sampled, the request is refused and the block stays Active.
- R5: In Active both status outputs are 0. Shallow sets `clk_reduce`=1 and `mem_pdown`=0. Deep, Dormant and Off set both outputs to 1.
- R6: In Shallow or Deep, any enabled event returns the block to Active. The mask bit positions are: 0 button rising edge, 1 charger either edge, 2 any I/O line edge, 3 digital-interface flag edge, 4 timer expiry, 5 LED flag edge, 6 debug flag edge, 7 USB resume rising edge.
- R7: An event whose `wake_mask` bit is 0 has no effect. The mask resets to 8'hFF and is written by `mask_we` with `mask_wdata`.
- R8: In Dormant, only button rise, charger edge, timer expiry and edges on `io_pin[8:1]` can wake the block. Each still needs its mask bit. An edge on `io_pin[0]` or above bit 8, and the interface, LED, debug and USB flags, are ignored.
- R9: When a sleep request is accepted, the wake timer loads `tmr_load`. It counts down one per tick and raises its expiry event when it reaches zero.
- R10: If `rst_pin_n` stays low for RST_TICKS consecutive ticks, the block is forced to Off. A shorter low pulse is ignored. After release, the block stays in Off until R2 is met.
- R11: `wake` is high for exactly one cycle, namely the first cycle in which `pwr_state` is Active after any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse at 1 MHz |
| btn_pin | input | 1 | Power-button pin, asynchronous |
| chg_pin | input | 1 | Charger-attach pin, asynchronous |
| io_pin | input | N_IO | General I/O lines, asynchronous |
| dif_act | input | 1 | Digital-interface activity flag |
| dbg_act | input | 1 | Debug-port activity flag |
| led_act | input | 1 | LED-input activity flag |
| usb_resume | input | 1 | USB resume flag |
| rst_pin_n | input | 1 | External active-low reset pin, asynchronous |
| mask_we | input | 1 | Wake-mask write strobe |
| mask_wdata | input | 8 | Wake-mask write data |
| sleep_req | input | 1 | Sleep request strobe |
| sleep_mode | input | 2 | Requested depth: 1 Shallow, 2 Deep, 3 Dormant |
| tmr_load | input | TMR_W | Wake-timer start value in ticks |
| pwr_state | output | 3 | 0 Off, 1 Active, 2 Shallow, 3 Deep, 4 Dormant |
| wake | output | 1 | One-cycle return-to-Active pulse |
| clk_reduce | output | 1 | Clock-reduction status |
| mem_pdown | output | 1 | Memory power-down status |

## Verification
The bench builds the block with HOLD_TICKS=20, RST_TICKS=6, N_IO=12 and TMR_W=12, and drives a tick every fourth clock. With these values a full Off-exit hold and a qualified reset-pin pulse each take under a hundred cycles, so both the short-pulse rejection and the restart after a gap can be driven many times. Twelve I/O lines are enough to reach the Dormant window edges, bits 0, 1, 8 and 9. A random mix of depth, source, line and mask is checked against a bench function of the wake rules.

// File: rtl/pwk_pkg.sv
// Shared types for the power-state and wake controller.
// Assumes: state codes are visible on a status port, so the values are fixed.
package pwk_pkg;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_ACTIVE  = 3'd1,
        PS_SHALLOW = 3'd2,
        PS_DEEP    = 3'd3,
        PS_DORMANT = 3'd4
    } pwr_state_e;

    localparam int SRC_N   = 8;
    localparam int SRC_BTN = 0;
    localparam int SRC_CHG = 1;
    localparam int SRC_IO  = 2;
    localparam int SRC_DIF = 3;
    localparam int SRC_TMR = 4;
    localparam int SRC_LED = 5;
    localparam int SRC_DBG = 6;
    localparam int SRC_USB = 7;

endpackage

// File: rtl/pwk_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes: every bit is independent; no multi-bit coherence is needed.
module pwk_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages that settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pwk_hold_qual.sv
// Level qualifier: done rises after lvl has been high for N consecutive ticks.
// Assumes: lvl is synchronous; clr or a low level restarts the count.
module pwk_hold_qual #(
    parameter int N = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    input  logic lvl,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LIM = CW'(N);

    logic [CW-1:0] cnt;

    // Count ticks while the level holds; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clr || !lvl)     cnt <= '0;
        else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/pwk_wake_eval.sv
// Edge detection and wake-source filtering for the current sleep depth.
// Assumes: all inputs are already synchronized; hit is combinational.
module pwk_wake_eval
    import pwk_pkg::*;
#(
    parameter int N_IO    = 20,
    parameter int DORM_LO = 1,
    parameter int DORM_HI = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            btn_s,
    input  logic            chg_s,
    input  logic [N_IO-1:0] io_s,
    input  logic            dif_s,
    input  logic            dbg_s,
    input  logic            led_s,
    input  logic            usb_s,
    input  logic            tmr_exp,
    input  logic [SRC_N-1:0] mask,
    input  logic            dormant,
    output logic            hit
);
    function automatic logic [N_IO-1:0] dorm_window();
        logic [N_IO-1:0] m;
        for (int i = 0; i < N_IO; i++) m[i] = (i >= DORM_LO) && (i <= DORM_HI);
        return m;
    endfunction

    localparam logic [N_IO-1:0] DORM_MASK = dorm_window();

    logic            btn_p, chg_p, dif_p, dbg_p, led_p, usb_p;
    logic [N_IO-1:0] io_p;
    logic [SRC_N-1:0] raw, sel;
    logic [N_IO-1:0] io_chg;

    // Keep last cycle's synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {btn_p, chg_p, dif_p, dbg_p, led_p, usb_p} <= '0;
            io_p <= '0;
        end else begin
            {btn_p, chg_p, dif_p, dbg_p, led_p, usb_p} <= {btn_s, chg_s, dif_s, dbg_s, led_s, usb_s};
            io_p <= io_s;
        end
    end

    // Form the per-source events and keep those the depth allows.
    always_comb begin
        io_chg       = io_s ^ io_p;
        raw          = '0;
        raw[SRC_BTN] = btn_s & ~btn_p;
        raw[SRC_CHG] = chg_s ^ chg_p;
        raw[SRC_IO]  = |io_chg;
        raw[SRC_DIF] = dif_s ^ dif_p;
        raw[SRC_TMR] = tmr_exp;
        raw[SRC_LED] = led_s ^ led_p;
        raw[SRC_DBG] = dbg_s ^ dbg_p;
        raw[SRC_USB] = usb_s & ~usb_p;
        sel          = raw;
        if (dormant) begin
            sel          = '0;
            sel[SRC_BTN] = raw[SRC_BTN];
            sel[SRC_CHG] = raw[SRC_CHG];
            sel[SRC_TMR] = raw[SRC_TMR];
            sel[SRC_IO]  = |(io_chg & DORM_MASK);
        end
        hit = |(sel & mask);
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
// Power-state sequencer: Off, Active and three sleep depths with wake logic.
// Assumes: tick_1us is a one-cycle pulse at 1 MHz; rst_n is synchronous;
// all pins other than the software controls are asynchronous.
module pwr_wake_ctrl
    import pwk_pkg::*;
#(
    parameter int N_IO       = 20,
    parameter int TMR_W      = 16,
    parameter int HOLD_TICKS = 20000,
    parameter int RST_TICKS  = 120,
    parameter int DORM_IO_LO = 1,
    parameter int DORM_IO_HI = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1us,
    input  logic             btn_pin,
    input  logic             chg_pin,
    input  logic [N_IO-1:0]  io_pin,
    input  logic             dif_act,
    input  logic             dbg_act,
    input  logic             led_act,
    input  logic             usb_resume,
    input  logic             rst_pin_n,
    input  logic             mask_we,
    input  logic [7:0]       mask_wdata,
    input  logic             sleep_req,
    input  logic [1:0]       sleep_mode,
    input  logic [TMR_W-1:0] tmr_load,
    output logic [2:0]       pwr_state,
    output logic             wake,
    output logic             clk_reduce,
    output logic             mem_pdown
);
    localparam int AW = N_IO + 6;

    pwr_state_e       state, nxt;
    logic [AW-1:0]    async_s;
    logic             btn_s, chg_s, dif_s, dbg_s, led_s, usb_s, rpin_s;
    logic [N_IO-1:0]  io_s;
    logic             btn_ok, chg_ok, rst_hold, hold_clr;
    logic             hit, sleeping, accept, tmr_exp, tmr_run;
    logic [TMR_W-1:0] tmr_cnt;
    logic [SRC_N-1:0] mask;

    pwk_sync #(.W(AW), .RST_VAL(1'b0)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({io_pin, btn_pin, chg_pin, dif_act, dbg_act, led_act, usb_resume}),
        .q(async_s)
    );
    assign {io_s, btn_s, chg_s, dif_s, dbg_s, led_s, usb_s} = async_s;

    pwk_sync #(.W(1), .RST_VAL(1'b1)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .d(rst_pin_n), .q(rpin_s)
    );

    assign hold_clr = (state != PS_OFF) || rst_hold;

    pwk_hold_qual #(.N(HOLD_TICKS)) u_q_btn (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .clr(hold_clr), .lvl(btn_s), .done(btn_ok)
    );
    pwk_hold_qual #(.N(HOLD_TICKS)) u_q_chg (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .clr(hold_clr), .lvl(chg_s), .done(chg_ok)
    );
    pwk_hold_qual #(.N(RST_TICKS)) u_q_rst (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .clr(1'b0), .lvl(!rpin_s), .done(rst_hold)
    );

    pwk_wake_eval #(.N_IO(N_IO), .DORM_LO(DORM_IO_LO), .DORM_HI(DORM_IO_HI)) u_eval (
        .clk(clk), .rst_n(rst_n),
        .btn_s(btn_s), .chg_s(chg_s), .io_s(io_s), .dif_s(dif_s), .dbg_s(dbg_s),
        .led_s(led_s), .usb_s(usb_s), .tmr_exp(tmr_exp), .mask(mask),
        .dormant(state == PS_DORMANT), .hit(hit)
    );

    assign sleeping = (state == PS_SHALLOW) || (state == PS_DEEP) || (state == PS_DORMANT);
    assign tmr_exp  = sleeping && tmr_run && (tmr_cnt == '0);

    // Software-written wake-source enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= mask_wdata;
    end

    // Next-state choice: forced Off, Off exit, sleep entry, wake.
    always_comb begin
        nxt = state;
        if (rst_hold) begin
            nxt = PS_OFF;
        end else begin
            case (state)
                PS_OFF:    if (btn_ok || chg_ok) nxt = PS_ACTIVE;
                PS_ACTIVE: if (sleep_req && !hit) begin
                    case (sleep_mode)
                        2'd1:    nxt = PS_SHALLOW;
                        2'd2:    nxt = PS_DEEP;
                        2'd3:    nxt = PS_DORMANT;
                        default: nxt = PS_ACTIVE;
                    endcase
                end
                PS_SHALLOW, PS_DEEP, PS_DORMANT: if (hit) nxt = PS_ACTIVE;
                default:   nxt = PS_OFF;
            endcase
        end
    end

    assign accept = (state == PS_ACTIVE) && (nxt != PS_ACTIVE) && (nxt != PS_OFF);

    // State register and one-cycle wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_OFF;
            wake  <= 1'b0;
        end else begin
            state <= nxt;
            wake  <= (nxt == PS_ACTIVE) && (state != PS_ACTIVE);
        end
    end

    // Wake timer: loaded on sleep entry, counts down on ticks while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_cnt <= '0;
            tmr_run <= 1'b0;
        end else if (accept) begin
            tmr_cnt <= tmr_load;
            tmr_run <= 1'b1;
        end else if (!sleeping || tmr_exp) begin
            tmr_run <= 1'b0;
        end else if (tick_1us && tmr_cnt != '0) begin
            tmr_cnt <= tmr_cnt - 1'b1;
        end
    end

    assign pwr_state  = state;
    assign clk_reduce = (state != PS_ACTIVE);
    assign mem_pdown  = (state == PS_OFF) || (state == PS_DEEP) || (state == PS_DORMANT);
endmodule

// File: rtl/pwk_chk.sv
// Checker for the power-state controller, bound to every instance of the top.
// Assumes: state codes as in pwk_pkg.
module pwk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state,
    input logic       wake,
    input logic       clk_reduce,
    input logic       mem_pdown
);
    AST_RESET_LANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> state == 3'd0); // R1
    AST_OFF_EXITS_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == 3'd0 && state != 3'd0) |-> state == 3'd1); // R2
    AST_SLEEP_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state >= 3'd2 && state != $past(state)) |-> $past(state) == 3'd1); // R3
    AST_SHALLOW_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd2 |-> clk_reduce && !mem_pdown); // R5
    AST_DEEP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3 || state == 3'd4) |-> clk_reduce && mem_pdown); // R5
    AST_WAKE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> state == 3'd1 && $past(state) != 3'd1); // R11
    AST_WAKE_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd1 && $past(state) != 3'd1 && $past(rst_n)) |-> wake); // R11
endmodule

bind pwr_wake_ctrl pwk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(pwr_state), .wake(wake),
    .clk_reduce(clk_reduce), .mem_pdown(mem_pdown)
);

// File: tb/sim_pwr_wake_ctrl.sv
module sim_pwr_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_IO = 12, TMR_W = 12, HOLD = 20, RSTQ = 6, TICK_DIV = 4;

    logic clk = 0, rst_n = 0, tick = 0;
    logic btn = 0, chg = 0, dif = 0, dbg = 0, led = 0, usb = 0, rpin_n = 1;
    logic [N_IO-1:0] io = '0;
    logic mask_we = 0, sleep_req = 0;
    logic [7:0] mask_wdata = '0;
    logic [1:0] sleep_mode = '0;
    logic [TMR_W-1:0] tmr_load = 12'd4000;
    logic [2:0] pwr_state;
    logic wake, clk_reduce, mem_pdown;
    int checks = 0, fails = 0, wake_cnt = 0;

    pwr_wake_ctrl #(.N_IO(N_IO), .TMR_W(TMR_W), .HOLD_TICKS(HOLD), .RST_TICKS(RSTQ)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick), .btn_pin(btn), .chg_pin(chg),
        .io_pin(io), .dif_act(dif), .dbg_act(dbg), .led_act(led), .usb_resume(usb),
        .rst_pin_n(rpin_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .sleep_req(sleep_req), .sleep_mode(sleep_mode), .tmr_load(tmr_load),
        .pwr_state(pwr_state), .wake(wake), .clk_reduce(clk_reduce), .mem_pdown(mem_pdown)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            tick = 1;
            @(negedge clk);
            tick = 0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (wake) wake_cnt++;
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_mask(logic [7:0] m);
        mask_wdata = m; mask_we = 1; cyc(1); mask_we = 0; cyc(1);
    endtask

    task automatic req_sleep(int mode);
        sleep_mode = 2'(mode); sleep_req = 1; cyc(1); sleep_req = 0; cyc(3);
    endtask

    task automatic fire(int src, int b);
        case (src)
            0: btn = 1;
            1: chg = ~chg;
            2: io[b] = ~io[b];
            3: dif = ~dif;
            5: led = ~led;
            6: dbg = ~dbg;
            default: usb = 1;
        endcase
        cyc(5);
    endtask

    function automatic bit exp_wake(int mode, int src, int b, logic [7:0] m);
        if (!m[src]) return 0;
        if (mode == 3) begin
            if (src == 0 || src == 1 || src == 4) return 1;
            if (src == 2) return (b >= 1 && b <= 8);
            return 0;
        end
        return 1;
    endfunction

    task automatic btn_wake();
        wr_mask(8'hFF);
        btn = 0; cyc(4); btn = 1; cyc(5); btn = 0; cyc(4);
    endtask

    initial begin
        void'($urandom(32'd2024));
        cyc(4); rst_n = 1; cyc(1);
        // R1 reset state
        chk("R1 state", pwr_state, 0);
        chk("R1 clk_reduce", clk_reduce, 1);
        chk("R1 mem_pdown", mem_pdown, 1);
        chk("R1 wake", wake_cnt, 0);

        // R2 two short pulses, not consecutive, stay Off
        btn = 1; cyc(TICK_DIV * (HOLD - 8)); btn = 0; cyc(4);
        btn = 1; cyc(TICK_DIV * (HOLD - 8)); btn = 0; cyc(4);
        chk("R2 short pulses", pwr_state, 0);
        chg = 1; cyc(TICK_DIV * (HOLD + 4) + 6);
        chk("R2 held exit", pwr_state, 1);
        chk("R11 wake count", wake_cnt, 1);
        chk("R5 active clk_reduce", clk_reduce, 0);
        chk("R5 active mem_pdown", mem_pdown, 0);

        // R3 mode 0 ignored
        req_sleep(0);
        chk("R3 mode0", pwr_state, 1);

        // Shallow, then digital-interface wake (R5, R6)
        req_sleep(1);
        chk("R3 shallow", pwr_state, 2);
        chk("R5 shallow clk_reduce", clk_reduce, 1);
        chk("R5 shallow mem_pdown", mem_pdown, 0);
        fire(3, 0);
        chk("R6 dif wake", pwr_state, 1);

        // R9 timer wake from Deep
        tmr_load = 12'd10;
        req_sleep(2);
        chk("R5 deep mem_pdown", mem_pdown, 1);
        cyc(20);
        chk("R9 before expiry", pwr_state, 3);
        cyc(28);
        chk("R9 after expiry", pwr_state, 1);
        tmr_load = 12'd4000;
        cyc(4);

        // R8 Dormant window
        req_sleep(3);
        chk("R3 dormant", pwr_state, 4);
        fire(2, 0);  chk("R8 io0 ignored", pwr_state, 4);
        fire(2, 9);  chk("R8 io9 ignored", pwr_state, 4);
        fire(3, 0);  chk("R8 dif ignored", pwr_state, 4);
        fire(2, 8);  chk("R8 io8 wakes", pwr_state, 1);
        cyc(4);

        // R4 refusal with pending enabled event
        dif = ~dif; cyc(2);
        sleep_mode = 2'd2; sleep_req = 1; cyc(1); sleep_req = 0; cyc(3);
        chk("R4 refused", pwr_state, 1);
        // R7 same pending event, masked: accepted
        wr_mask(8'hF7); cyc(4);
        dif = ~dif; cyc(2);
        sleep_mode = 2'd2; sleep_req = 1; cyc(1); sleep_req = 0; cyc(3);
        chk("R7 masked pending", pwr_state, 3);
        btn_wake();
        chk("R6 btn wake", pwr_state, 1);

        // Random mix: depth, source, line, mask (R6, R7, R8)
        for (int i = 0; i < 40; i++) begin
            int mode, src, b, w0;
            logic [7:0] m;
            bit ew;
            mode = $urandom_range(1, 3);
            src  = $urandom_range(0, 6);
            if (src >= 4) src++;
            b    = $urandom_range(0, N_IO - 1);
            m    = 8'($urandom);
            ew   = exp_wake(mode, src, b, m);
            wr_mask(m);
            req_sleep(mode);
            chk("R3 random entry", pwr_state, mode + 1);
            w0 = wake_cnt;
            fire(src, b);
            chk(mode == 3 ? "R8 random" : (m[src] ? "R6 random" : "R7 random"),
                pwr_state, ew ? 1 : mode + 1);
            if (ew) chk("R11 one pulse", wake_cnt - w0, 1);
            btn = 0; usb = 0; cyc(4);
            if (pwr_state != 3'd1) btn_wake();
            cyc(4);
        end

        // R10 reset pin
        rpin_n = 0; cyc(TICK_DIV * (RSTQ - 3)); rpin_n = 1; cyc(5);
        chk("R10 short low ignored", pwr_state, 1);
        rpin_n = 0; cyc(TICK_DIV * RSTQ + 12);
        chk("R10 forced off", pwr_state, 0);
        rpin_n = 1; cyc(8);
        chk("R10 stays off", pwr_state, 0);
        btn = 1; cyc(TICK_DIV * (HOLD + 4) + 6); btn = 0;
        chk("R2 exit after pin reset", pwr_state, 1);
        cyc(4);
        finish_run();
    end
endmodule